// File: doc/BRIEF.md
# Dual-Row Quad-Cell Scan Address Generator

This block walks a bit-addressed canvas and reads it out as 2x2 cells. It treats each pair of adjacent rows as one band. It moves left to right across that band in two-column steps. For every step it presents four bit addresses to a canvas memory in the same cycle: top-left, bottom-left, top-right and bottom-right. The memory answers one cycle later. The block passes the four returned bits downstream as one 4-bit quad, tagged with the cell's index inside the band.

A start pulse latches the canvas base address and begins the walk. After the last cell of a band the band base jumps down two rows and the index starts again at zero. After the last band the block raises a one-cycle done pulse and returns to idle.

The output is a valid/ready stream. When the consumer holds ready low, the block keeps the current quad on its outputs. It re-presents that quad's addresses so the memory keeps returning the same bits. The walk does not advance during the stall, and no cell is lost or repeated.

Top module: `quad_scan_top`

## Requirements
- R1: When a new cell is read, the top-left address equals the band base plus twice the cell index. The band base of the first band equals the base sampled on start.
- R2: Whenever the read enable is high, the bottom-left address is the top-left plus the row width (1500), the top-right is the top-left plus 1, and the bottom-right is the top-left plus 1501, all in the same cycle.
- R3: The cell index on the output tag runs 0 to 749 within a band, increasing by one per accepted quad.
- R4: After cell 749 the band base advances by 3000 bits (two rows) and the index restarts at 0.
- R5: Output quad bit 0 is the bit read at the top-left address, bit 1 bottom-left, bit 2 top-right, bit 3 bottom-right.
- R6: The output valid is high only in a cycle that follows a cycle with the read enable high. With ready held high the block delivers one quad per cycle, so a full canvas finishes within 3002 cycles of the start.
- R7: While valid is high and ready is low, the quad and its tag hold steady on the following cycle, and every quad is delivered exactly once.
- R8: done pulses high for exactly one cycle, the cycle after the 3000th quad (four bands) is accepted. In that cycle valid is low.
- R9: start is ignored while a walk is in progress. The base input is sampled only on an accepted start.
- R10: After reset, valid, done and read enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| base_i | input | ADDR_W | Bit address of the canvas's top-left bit |
| done_o | output | 1 | One-cycle pulse after the final quad is accepted |
| rd_en_o | output | 1 | Read request for the four addresses |
| rd_tl_addr_o | output | ADDR_W | Top-left bit address |
| rd_bl_addr_o | output | ADDR_W | Bottom-left bit address |
| rd_tr_addr_o | output | ADDR_W | Top-right bit address |
| rd_br_addr_o | output | ADDR_W | Bottom-right bit address |
| rd_data_i | input | 4 | Bits returned one cycle after the request, in address order TL, BL, TR, BR |
| q_valid_o | output | 1 | Quad available |
| q_ready_i | input | 1 | Consumer accepts the quad |
| q_data_o | output | 4 | Quad bits: [0] TL, [1] BL, [2] TR, [3] BR |
| q_blk_o | output | BLK_W | Cell index of the quad within its band |

## Verification
The hardest case to reach is a stall that falls in the cycle a new read would be issued. The block must then present the held cell's addresses again instead of the next cell's, and do so across the jump from cell 749 to the next band. The bench drives ready from a pseudo-random pattern and from long low bursts over whole canvases, so stalls land at band boundaries and on the very last cell. At every cycle it predicts which address the read port must carry, either the held cell or the next one in order. One walk also receives a second start with a different base part way through.

// File: rtl/qscan_pkg.sv
package qscan_pkg;

    // Controller state: waiting for start, or walking the canvas.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } scan_state_e;

    // Offset of quadrant idx from the top-left bit of a cell.
    // Index order is the quad bit order: TL, BL, TR, BR.
    function automatic int unsigned quad_offset(input int idx, input int unsigned row_w);
        case (idx)
            0:       return 0;
            1:       return row_w;
            2:       return 1;
            default: return row_w + 1;
        endcase
    endfunction

endpackage

// File: rtl/qscan_quad_addr.sv
module qscan_quad_addr
    import qscan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 1500
) (
    input  logic [ADDR_W-1:0]       tl_i,
    output logic [3:0][ADDR_W-1:0]  addr_o
);

    for (genvar q = 0; q < 4; q++) begin : g_quad
        localparam int unsigned OFS = quad_offset(q, ROW_W);
        assign addr_o[q] = tl_i + ADDR_W'(OFS);
    end

endmodule

// File: rtl/qscan_walker.sv
module qscan_walker #(
    parameter int ADDR_W    = 16,
    parameter int ROW_W     = 1500,
    parameter int ROW_PAIRS = 4,
    localparam int BLK_N    = ROW_W / 2,
    localparam int BLK_W    = $clog2(BLK_N),
    localparam int PAIR_W   = (ROW_PAIRS > 1) ? $clog2(ROW_PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] tl_o,
    output logic [BLK_W-1:0]  blk_o,
    output logic              last_o
);

    localparam logic [ADDR_W-1:0] BAND_STRIDE = ADDR_W'(2 * ROW_W);

    logic [ADDR_W-1:0] band_base_q;
    logic [BLK_W-1:0]  blk_q;
    logic [PAIR_W-1:0] pair_q;
    logic              band_end;

    assign band_end = (blk_q == BLK_W'(BLK_N - 1));
    assign last_o   = band_end && (pair_q == PAIR_W'(ROW_PAIRS - 1));
    assign tl_o     = band_base_q + (ADDR_W'(blk_q) << 1);
    assign blk_o    = blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            band_base_q <= '0;
            blk_q       <= '0;
            pair_q      <= '0;
        end else if (load_i) begin
            band_base_q <= base_i;
            blk_q       <= '0;
            pair_q      <= '0;
        end else if (step_i) begin
            if (band_end) begin
                blk_q       <= '0;
                pair_q      <= pair_q + 1'b1;
                band_base_q <= band_base_q + BAND_STRIDE;
            end else begin
                blk_q <= blk_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/quad_scan_top.sv
module quad_scan_top
    import qscan_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROW_W     = 1500,
    parameter int ROW_PAIRS = 4,
    localparam int BLK_W    = $clog2(ROW_W / 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              done_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_tl_addr_o,
    output logic [ADDR_W-1:0] rd_bl_addr_o,
    output logic [ADDR_W-1:0] rd_tr_addr_o,
    output logic [ADDR_W-1:0] rd_br_addr_o,
    input  logic [3:0]        rd_data_i,
    output logic              q_valid_o,
    input  logic              q_ready_i,
    output logic [3:0]        q_data_o,
    output logic [BLK_W-1:0]  q_blk_o
);

    // Cell currently sitting on the output stage.
    typedef struct packed {
        logic [ADDR_W-1:0] tl;
        logic [BLK_W-1:0]  blk;
        logic              last;
    } held_cell_t;

    scan_state_e       state_q;
    logic              issuing_q;
    logic              valid_q;
    logic              done_q;
    held_cell_t        held_q;

    logic              accept_start;
    logic              stall;
    logic              issue;
    logic              fire;
    logic [ADDR_W-1:0] walk_tl;
    logic [BLK_W-1:0]  walk_blk;
    logic              walk_last;
    logic [ADDR_W-1:0] sel_tl;
    logic [3:0][ADDR_W-1:0] quad_addr;

    assign accept_start = start_i && (state_q == ST_IDLE);
    assign stall        = valid_q && !q_ready_i;
    assign fire         = valid_q && q_ready_i;
    assign issue        = issuing_q && !stall;

    qscan_walker #(
        .ADDR_W    (ADDR_W),
        .ROW_W     (ROW_W),
        .ROW_PAIRS (ROW_PAIRS)
    ) u_walker (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept_start),
        .base_i (base_i),
        .step_i (issue),
        .tl_o   (walk_tl),
        .blk_o  (walk_blk),
        .last_o (walk_last)
    );

    // A stalled cell is read again so the memory keeps returning its bits.
    assign sel_tl = stall ? held_q.tl : walk_tl;

    qscan_quad_addr #(
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W)
    ) u_quad_addr (
        .tl_i   (sel_tl),
        .addr_o (quad_addr)
    );

    assign rd_en_o      = issue || stall;
    assign rd_tl_addr_o = quad_addr[0];
    assign rd_bl_addr_o = quad_addr[1];
    assign rd_tr_addr_o = quad_addr[2];
    assign rd_br_addr_o = quad_addr[3];

    assign q_valid_o = valid_q;
    assign q_data_o  = rd_data_i;
    assign q_blk_o   = held_q.blk;
    assign done_o    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            issuing_q <= 1'b0;
            valid_q   <= 1'b0;
            done_q    <= 1'b0;
            held_q    <= '0;
        end else begin
            done_q <= 1'b0;

            if (accept_start) begin
                state_q   <= ST_RUN;
                issuing_q <= 1'b1;
            end

            if (issue) begin
                valid_q     <= 1'b1;
                held_q.tl   <= walk_tl;
                held_q.blk  <= walk_blk;
                held_q.last <= walk_last;
                if (walk_last) begin
                    issuing_q <= 1'b0;
                end
            end else if (!stall) begin
                valid_q <= 1'b0;
            end

            if (fire && held_q.last) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/qscan_checker.sv
module qscan_checker #(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 1500,
    parameter int BLK_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en_o,
    input logic [ADDR_W-1:0] rd_tl_addr_o,
    input logic [ADDR_W-1:0] rd_bl_addr_o,
    input logic [ADDR_W-1:0] rd_tr_addr_o,
    input logic [ADDR_W-1:0] rd_br_addr_o,
    input logic              q_valid_o,
    input logic              q_ready_i,
    input logic [BLK_W-1:0]  q_blk_o,
    input logic              done_o
);

    a_r2_quad_offsets: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> (rd_bl_addr_o == rd_tl_addr_o + ADDR_W'(ROW_W))
                 && (rd_tr_addr_o == rd_tl_addr_o + ADDR_W'(1))
                 && (rd_br_addr_o == rd_tl_addr_o + ADDR_W'(ROW_W + 1)));

    a_r3_blk_range: assert property (@(posedge clk) disable iff (rst)
        q_valid_o |-> (int'(q_blk_o) < ROW_W / 2));

    a_r6_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        q_valid_o |-> $past(rd_en_o));

    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (q_valid_o && !q_ready_i) |=> (q_valid_o && $stable(q_blk_o)));

    a_r7_reread_on_stall: assert property (@(posedge clk) disable iff (rst)
        (q_valid_o && !q_ready_i) |-> rd_en_o);

    a_r8_done_no_valid: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !q_valid_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind quad_scan_top qscan_checker #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W),
    .BLK_W  (BLK_W)
) u_qscan_checker (
    .clk          (clk),
    .rst          (rst),
    .rd_en_o      (rd_en_o),
    .rd_tl_addr_o (rd_tl_addr_o),
    .rd_bl_addr_o (rd_bl_addr_o),
    .rd_tr_addr_o (rd_tr_addr_o),
    .rd_br_addr_o (rd_br_addr_o),
    .q_valid_o    (q_valid_o),
    .q_ready_i    (q_ready_i),
    .q_blk_o      (q_blk_o),
    .done_o       (done_o)
);

// File: tb/tb_quad_scan_top.sv
module tb_quad_scan_top;

    localparam int ADDR_W = 16;
    localparam int ROW_W  = 1500;
    localparam int PAIRS  = 4;
    localparam int BLK_N  = ROW_W / 2;
    localparam int BLK_W  = $clog2(BLK_N);
    localparam int CELLS  = BLK_N * PAIRS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic              done_o;
    logic              rd_en_o;
    logic [ADDR_W-1:0] rd_tl_addr_o, rd_bl_addr_o, rd_tr_addr_o, rd_br_addr_o;
    logic [3:0]        rd_data_i = '0;
    logic              q_valid_o;
    logic              q_ready_i = 1'b1;
    logic [3:0]        q_data_o;
    logic [BLK_W-1:0]  q_blk_o;

    always #4 clk = ~clk;

    quad_scan_top dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .base_i       (base_i),
        .done_o       (done_o),
        .rd_en_o      (rd_en_o),
        .rd_tl_addr_o (rd_tl_addr_o),
        .rd_bl_addr_o (rd_bl_addr_o),
        .rd_tr_addr_o (rd_tr_addr_o),
        .rd_br_addr_o (rd_br_addr_o),
        .rd_data_i    (rd_data_i),
        .q_valid_o    (q_valid_o),
        .q_ready_i    (q_ready_i),
        .q_data_o     (q_data_o),
        .q_blk_o      (q_blk_o)
    );

    // Canvas content: a fixed function of the bit address.
    function automatic logic cell_bit(input logic [ADDR_W-1:0] a);
        return a[0] ^ a[2] ^ a[5] ^ a[9] ^ (a[3] & a[11]) ^ (a[1] & a[7]);
    endfunction

    function automatic logic [ADDR_W-1:0] cell_tl(input int base, input int idx);
        return ADDR_W'(base + (idx / BLK_N) * 2 * ROW_W + 2 * (idx % BLK_N));
    endfunction

    // Memory model: one-cycle read latency.
    always @(posedge clk) begin
        if (rd_en_o)
            rd_data_i <= {cell_bit(rd_br_addr_o), cell_bit(rd_tr_addr_o),
                          cell_bit(rd_bl_addr_o), cell_bit(rd_tl_addr_o)};
    end

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard of expected quads.
    logic [3:0]       exp_data[$];
    logic [BLK_W-1:0] exp_blk[$];

    task automatic push_run(input int base);
        for (int i = 0; i < CELLS; i++) begin
            logic [ADDR_W-1:0] t;
            t = cell_tl(base, i);
            exp_data.push_back({cell_bit(t + ADDR_W'(ROW_W + 1)), cell_bit(t + ADDR_W'(1)),
                                cell_bit(t + ADDR_W'(ROW_W)), cell_bit(t)});
            exp_blk.push_back(BLK_W'(i % BLK_N));
        end
    endtask

    // Ready driver: mode 0 always high, 1 pseudo-random, 2 long bursts.
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int          cyc = 0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (ready_mode)
                0:       q_ready_i = 1'b1;
                1:       q_ready_i = lfsr[0] | lfsr[3];
                default: q_ready_i = ((cyc % 23) < 9) ? 1'b0 : 1'b1;
            endcase
        end
    end

    // Monitor: address prediction, stall hold and scoreboard.
    int          run_base = 0;
    int          issue_idx = 0;
    bit          prev_stall = 0;
    logic [3:0]  prev_data;
    logic [BLK_W-1:0] prev_blk;
    logic [ADDR_W-1:0] held_tl;

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_en_o) begin
                // R2: the four addresses of one cell in the same cycle
                check(rd_bl_addr_o == rd_tl_addr_o + ADDR_W'(ROW_W) &&
                      rd_tr_addr_o == rd_tl_addr_o + ADDR_W'(1) &&
                      rd_br_addr_o == rd_tl_addr_o + ADDR_W'(ROW_W + 1),
                      "R2", "quad offsets", rd_br_addr_o, rd_tl_addr_o + ROW_W + 1);
                if (q_valid_o && !q_ready_i) begin
                    // R7: stalled cell is read again
                    check(rd_tl_addr_o == held_tl, "R7", "re-read address",
                          rd_tl_addr_o, held_tl);
                end else begin
                    // R1 / R4: next cell in band order
                    check(rd_tl_addr_o == cell_tl(run_base, issue_idx), "R1_R4",
                          "top-left address", rd_tl_addr_o, cell_tl(run_base, issue_idx));
                    held_tl = rd_tl_addr_o;
                    issue_idx++;
                end
            end
            if (prev_stall) begin
                check(q_valid_o && q_data_o == prev_data && q_blk_o == prev_blk,
                      "R7", "held quad", {q_valid_o, q_blk_o, q_data_o},
                      {1'b1, prev_blk, prev_data});
            end
            if (q_valid_o && q_ready_i) begin
                if (exp_data.size() == 0) begin
                    check(0, "R8", "quad after end of canvas", q_blk_o, -1);
                end else begin
                    logic [3:0]       ed;
                    logic [BLK_W-1:0] eb;
                    ed = exp_data.pop_front();
                    eb = exp_blk.pop_front();
                    check(q_data_o == ed, "R5", "quad bits", q_data_o, ed);
                    check(q_blk_o == eb, "R3", "cell index tag", q_blk_o, eb);
                end
            end
            prev_stall = q_valid_o && !q_ready_i;
            prev_data  = q_data_o;
            prev_blk   = q_blk_o;
        end
    end

    task automatic do_start(input int base);
        @(posedge clk);
        #1;
        base_i   = ADDR_W'(base);
        start_i  = 1'b1;
        @(posedge clk);
        #1;
        start_i  = 1'b0;
        base_i   = ADDR_W'(16'h5A5A);
    endtask

    // Waits for done with a watchdog; returns cycles waited.
    task automatic wait_done(output int cycles, input int limit);
        cycles = 0;
        forever begin
            @(negedge clk);
            cycles++;
            if (done_o) break;
            if (cycles >= limit) begin
                fails++;
                checks++;
                $display("FAIL watchdog: done not seen actual=%0d expected<%0d", cycles, limit);
                break;
            end
        end
    endtask

    task automatic end_of_run_checks;
        // R8: done lasts one cycle, valid low with it, all quads delivered
        check(!q_valid_o, "R8", "valid during done", q_valid_o, 0);
        check(exp_data.size() == 0, "R8", "quads left at done", exp_data.size(), 0);
        @(negedge clk);
        check(!done_o, "R8", "done width", done_o, 0);
        check(!q_valid_o && !rd_en_o, "R8", "idle after done", {q_valid_o, rd_en_o}, 0);
    endtask

    initial begin
        int n;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!q_valid_o, "R10", "valid after reset", q_valid_o, 0);
        check(!done_o, "R10", "done after reset", done_o, 0);
        check(!rd_en_o, "R10", "read enable after reset", rd_en_o, 0);

        // Run A: ready always high, base 0, second start mid-walk (R9)
        ready_mode = 0;
        run_base = 0; issue_idx = 0;
        push_run(0);
        do_start(0);
        repeat (1000) @(negedge clk);
        do_start(999);
        wait_done(n, 40000);
        // R6: one quad per cycle at full ready (about 1000 + 2 cycles already spent)
        check(n + 1002 <= 3002 + 2, "R6", "cycles for full canvas", n + 1002, 3002);
        check(issue_idx == CELLS, "R9", "cells read despite second start", issue_idx, CELLS);
        end_of_run_checks();

        // Run B: pseudo-random ready, base 300
        ready_mode = 1;
        run_base = 300; issue_idx = 0;
        push_run(300);
        do_start(300);
        wait_done(n, 60000);
        end_of_run_checks();

        // Run C: long stall bursts, base 1234
        ready_mode = 2;
        run_base = 1234; issue_idx = 0;
        push_run(1234);
        do_start(1234);
        wait_done(n, 60000);
        end_of_run_checks();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule